// File: doc/BRIEF.md
# Framed Synchronous Serial Transmitter

This block is the transmit half of a synchronous serial port meant for audio and telephony sample streams. Parallel words are written into an eight-entry queue. From there they are loaded into a shift stage and sent one bit per serial-clock period on a single data line. The word length can be anything from 3 to 32 bits, and the bit order can be most-significant-first or least-significant-first.

The serial clock comes from one of two places. It can be divided down from the system clock, with a 16-bit divisor, or it can be taken from an input pin. New data and new frame-sync levels are launched on each falling serial-clock edge, so a receiver can sample them on the rising edge.

Word framing has three options:
- no frame sync at all;
- a frame sync generated inside the block;
- a frame sync received on an input pin.

A generated frame sync has a selectable polarity and width, and it can be early or late relative to the first data bit. A pulse marks each finished word. A sticky flag records that the queue ran dry at the moment a word had to be loaded.

Top module: `frame_serial_tx`

## Requirements
- R1: `cfg_len_m1` holds the word length minus one (2..31 gives 3..32 bits). Each word occupies exactly that many consecutive serial-clock periods ("slots"), and a slot starts at a falling serial-clock edge.
- R2: When `cfg_lsb_first` is 0, the slots of a word carry bit L-1 down to bit 0. When it is 1, they carry bit 0 up to bit L-1.
- R3: The queue holds 8 words. `wr_full` is 1 while 8 words are held, and a write presented while `wr_full` is 1 is discarded.
- R4: When `cfg_int_clk` is 1, `sclk_out` has a period of 2×(`cfg_div`+1) system clocks, so a divisor of 0..65534 gives the system clock divided by 2 up to 131,070. `sd_out` and `fs_out` change only on the system-clock edge at which `sclk_out` falls.
- R5: When `cfg_int_clk` is 0, each falling edge of `sclk_in`, after a two-stage synchronizer, starts a slot, and `sclk_out` stays 0.
- R6: Without an external frame sync, sending starts at the first falling edge at which the queue holds a word. From then on, words follow each other with no gap.
- R7: When `cfg_fs_on` is 0, or when the frame sync is external, `fs_out` stays at its inactive level, which equals `cfg_fs_low`.
- R8: With the internal late frame sync (`cfg_fs_late`=1), a narrow pulse is active only in the first-bit slot of each word. The wide form (`cfg_fs_wide`=1) is active in every slot of every word.
- R9: With the internal early frame sync (`cfg_fs_late`=0), one lead slot with `sd_out`=0 and the frame sync active comes before the first word. After that, the narrow form is active in the last-bit slot of each word, which is the slot just before the next word's first bit. The wide form is active in every slot.
- R10: `fs_out` equals the active frame-sync level XOR `cfg_fs_low`, so `cfg_fs_low`=1 makes the frame sync active low.
- R11: With an external frame sync, `fs_in` (XOR `cfg_fs_low`) is sampled at each falling edge while the block is idle, and again at the end of each word. In late mode the first bit is launched at the same edge. In early mode it is launched at the next edge. `sd_out` is 0 while the block waits.
- R12: `word_done` is a one-cycle pulse. It is issued on the edge that ends the last-bit slot of a word.
- R13: If a word must be loaded while the queue is empty, the previous word is sent again and `uflow_err` is set. `uflow_err` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_len_m1 | input | 5 | Word length minus one |
| cfg_lsb_first | input | 1 | 1: least significant bit first |
| cfg_int_clk | input | 1 | 1: serial clock from the divider |
| cfg_div | input | 16 | Divider value |
| cfg_fs_on | input | 1 | Frame sync enable |
| cfg_fs_int | input | 1 | 1: frame sync generated inside |
| cfg_fs_low | input | 1 | Frame sync active low |
| cfg_fs_wide | input | 1 | Frame sync width equals the word length |
| cfg_fs_late | input | 1 | 1: late frame sync, 0: early frame sync |
| wr_en | input | 1 | Write strobe for the queue |
| wr_data | input | 32 | Word to queue, right-aligned |
| wr_full | output | 1 | Queue full |
| sclk_in | input | 1 | External serial clock |
| fs_in | input | 1 | External frame sync |
| sclk_out | output | 1 | Generated serial clock |
| fs_out | output | 1 | Generated frame sync |
| sd_out | output | 1 | Serial data |
| word_done | output | 1 | Word-complete pulse |
| uflow_err | output | 1 | Sticky underflow flag |

## Verification
Three events can fall on the same falling serial-clock edge: the word-complete pulse, the load of the next word, and an underflow. The bench provokes this by writing fewer words than the number of slots it observes. At the edge where the queue runs dry, the expected slot sequence must show the last word again, `word_done` must be high in that same slot, and the underflow flag must be set. The queue-full case collides a ninth write with the first pop, and the bench expects that word never to appear in the stream.

// File: rtl/ftx_pkg.sv
package ftx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_SHIFT = 2'd2
  } ftx_state_t;
endpackage

// File: rtl/ftx_bitclk.sv
module ftx_bitclk #(
  parameter int DIVW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            use_int,
  input  logic [DIVW-1:0] div,
  input  logic            sclk_ext,
  output logic            sclk_o,
  output logic            tick
);
  logic [DIVW-1:0] cnt;
  logic            sclk_q;
  logic [2:0]      ext_sync;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      sclk_q   <= 1'b0;
      ext_sync <= '0;
    end else begin
      ext_sync <= {ext_sync[1:0], sclk_ext};
      if (use_int) begin
        if (cnt == div) begin
          cnt    <= '0;
          sclk_q <= ~sclk_q;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        cnt    <= '0;
        sclk_q <= 1'b0;
      end
    end
  end

  // falling edge of the serial clock: launch point for data and frame sync
  assign tick   = use_int ? (sclk_q && (cnt == div)) : (ext_sync[2] && !ext_sync[1]);
  assign sclk_o = sclk_q;
endmodule

// File: rtl/ftx_fifo.sv
module ftx_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push_req,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty,
  output logic [AW:0]  level
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          push;

  assign push  = push_req && !full;
  assign full  = (level == (AW+1)'(DEPTH));
  assign empty = (level == '0);
  assign dout  = mem[rptr];

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (push) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
      case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/frame_serial_tx.sv
module frame_serial_tx
  import ftx_pkg::*;
#(
  parameter int WMAX  = 32,
  parameter int DEPTH = 8,
  parameter int DIVW  = 16,
  parameter int LW    = $clog2(WMAX),
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [LW-1:0]   cfg_len_m1,
  input  logic            cfg_lsb_first,
  input  logic            cfg_int_clk,
  input  logic [DIVW-1:0] cfg_div,
  input  logic            cfg_fs_on,
  input  logic            cfg_fs_int,
  input  logic            cfg_fs_low,
  input  logic            cfg_fs_wide,
  input  logic            cfg_fs_late,
  input  logic            wr_en,
  input  logic [WMAX-1:0] wr_data,
  output logic            wr_full,
  input  logic            sclk_in,
  input  logic            fs_in,
  output logic            sclk_out,
  output logic            fs_out,
  output logic            sd_out,
  output logic            word_done,
  output logic            uflow_err
);
  logic            tick;
  logic [WMAX-1:0] fifo_head;
  logic            fifo_empty, fifo_pop;
  logic [AW:0]     fifo_level;

  ftx_bitclk #(.DIVW(DIVW)) u_bitclk (
    .clk(clk), .rst(rst), .use_int(cfg_int_clk), .div(cfg_div),
    .sclk_ext(sclk_in), .sclk_o(sclk_out), .tick(tick)
  );

  ftx_fifo #(.W(WMAX), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push_req(wr_en), .pop(fifo_pop), .din(wr_data),
    .dout(fifo_head), .full(wr_full), .empty(fifo_empty), .level(fifo_level)
  );

  ftx_state_t      state, nstate;
  logic [LW-1:0]   cnt, ncnt;
  logic [WMAX-1:0] word_q, nword, load_word;
  logic [1:0]      fs_sync;
  logic            fs_seen, ext_fs, int_early, last_bit;
  logic            start_now, lead_now, nsd, nfs_act;

  function automatic logic pick(input logic [WMAX-1:0] w, input logic [LW-1:0] idx,
                                input logic [LW-1:0] len, input logic lsb);
    pick = lsb ? w[idx] : w[len - idx];
  endfunction

  assign fs_seen   = fs_sync[1] ^ cfg_fs_low;
  assign ext_fs    = cfg_fs_on && !cfg_fs_int;
  assign int_early = cfg_fs_on && cfg_fs_int && !cfg_fs_late;
  assign last_bit  = (cnt == cfg_len_m1);
  assign load_word = fifo_empty ? word_q : fifo_head;
  assign fifo_pop  = tick && start_now && !fifo_empty;

  always_comb begin
    start_now = 1'b0;
    lead_now  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (ext_fs) begin
          start_now = fs_seen && cfg_fs_late;
          lead_now  = fs_seen && !cfg_fs_late;
        end else begin
          start_now = !fifo_empty && !int_early;
          lead_now  = !fifo_empty && int_early;
        end
      end
      ST_LEAD: start_now = 1'b1;
      default: begin
        if (last_bit) begin
          if (ext_fs) begin
            start_now = fs_seen && cfg_fs_late;
            lead_now  = fs_seen && !cfg_fs_late;
          end else begin
            start_now = 1'b1;
          end
        end
      end
    endcase

    nstate = ST_IDLE;
    ncnt   = '0;
    nword  = word_q;
    nsd    = 1'b0;
    if (start_now) begin
      nstate = ST_SHIFT;
      nword  = load_word;
      nsd    = pick(load_word, '0, cfg_len_m1, cfg_lsb_first);
    end else if (lead_now) begin
      nstate = ST_LEAD;
    end else if (state == ST_SHIFT && !last_bit) begin
      nstate = ST_SHIFT;
      ncnt   = LW'(cnt + 1'b1);
      nsd    = pick(word_q, ncnt, cfg_len_m1, cfg_lsb_first);
    end

    nfs_act = cfg_fs_on && cfg_fs_int &&
              ((nstate == ST_LEAD) ||
               ((nstate == ST_SHIFT) &&
                (cfg_fs_wide || (cfg_fs_late ? (ncnt == '0) : (ncnt == cfg_len_m1)))));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      word_q    <= '0;
      sd_out    <= 1'b0;
      fs_out    <= cfg_fs_low;
      word_done <= 1'b0;
      uflow_err <= 1'b0;
      fs_sync   <= '0;
    end else begin
      fs_sync   <= {fs_sync[0], fs_in};
      word_done <= tick && (state == ST_SHIFT) && last_bit;
      if (tick) begin
        state     <= nstate;
        cnt       <= ncnt;
        word_q    <= nword;
        sd_out    <= nsd;
        fs_out    <= nfs_act ^ cfg_fs_low;
        uflow_err <= uflow_err | (start_now && fifo_empty);
      end
    end
  end
endmodule

// File: rtl/ftx_checker.sv
module ftx_checker #(
  parameter int DEPTH = 8,
  parameter int LVW   = $clog2(DEPTH) + 1
) (
  input logic           clk,
  input logic           rst,
  input logic           tick,
  input logic           sd_out,
  input logic           word_done,
  input logic           uflow_err,
  input logic           wr_en,
  input logic           wr_full,
  input logic [LVW-1:0] level
);
  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    word_done |=> !word_done);

  // R13
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    uflow_err |=> uflow_err);

  // R3
  level_bound_chk: assert property (@(posedge clk) disable iff (rst)
    level <= LVW'(DEPTH));

  // R3
  full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_full && wr_en) |=> (level <= $past(level)));

  // R4
  sd_on_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (sd_out != $past(sd_out)) |-> $past(tick));
endmodule

bind frame_serial_tx ftx_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .sd_out(sd_out), .word_done(word_done),
  .uflow_err(uflow_err), .wr_en(wr_en), .wr_full(wr_full), .level(fifo_level)
);

// File: tb/frame_serial_tx_test.sv
module frame_serial_tx_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst = 1'b1;
  logic [4:0]  cfg_len_m1 = 5'd7;
  logic        cfg_lsb_first = 1'b0, cfg_int_clk = 1'b1;
  logic [15:0] cfg_div = 16'd4;
  logic        cfg_fs_on = 1'b0, cfg_fs_int = 1'b1, cfg_fs_low = 1'b0;
  logic        cfg_fs_wide = 1'b0, cfg_fs_late = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        sclk_in = 1'b0, fs_in = 1'b0;
  logic        wr_full, sclk_out, fs_out, sd_out, word_done, uflow_err;

  frame_serial_tx uut (
    .clk(clk), .rst(rst), .cfg_len_m1(cfg_len_m1), .cfg_lsb_first(cfg_lsb_first),
    .cfg_int_clk(cfg_int_clk), .cfg_div(cfg_div), .cfg_fs_on(cfg_fs_on),
    .cfg_fs_int(cfg_fs_int), .cfg_fs_low(cfg_fs_low), .cfg_fs_wide(cfg_fs_wide),
    .cfg_fs_late(cfg_fs_late), .wr_en(wr_en), .wr_data(wr_data), .wr_full(wr_full),
    .sclk_in(sclk_in), .fs_in(fs_in), .sclk_out(sclk_out), .fs_out(fs_out),
    .sd_out(sd_out), .word_done(word_done), .uflow_err(uflow_err)
  );

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  int g_L, g_n;
  bit g_lsb, g_on, g_int, g_low, g_wide, g_late;
  logic [31:0] wv [16];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mkword(input int k, input int L);
    logic [63:0] m;
    m = (64'd1 << L) - 64'd1;
    return ((32'h9E3779B9 * (k + 3)) ^ (32'h01000193 * L)) & m[31:0];
  endfunction

  function automatic int lead_slots();
    return (g_on && g_int && !g_late) ? 1 : 0;
  endfunction

  function automatic int n_eff();
    return (g_n > 8) ? 8 : g_n;
  endfunction

  task automatic exp_slot(input int j, output logic sd, output logic fs, output logic dn);
    int pos, k, i;
    logic fa;
    logic [31:0] w;
    pos = j - lead_slots();
    if (pos < 0) begin
      sd = 1'b0; fa = 1'b1; dn = 1'b0;
    end else begin
      k = pos / g_L;
      i = pos % g_L;
      if (k > n_eff() - 1) k = n_eff() - 1;
      w  = wv[k];
      sd = g_lsb ? w[i] : w[g_L-1-i];
      if (!(g_on && g_int)) fa = 1'b0;
      else if (g_wide)      fa = 1'b1;
      else if (g_late)      fa = (i == 0);
      else                  fa = (i == g_L - 1);
      dn = (pos >= 1) && (i == 0);
    end
    fs = fa ^ g_low;
  endtask

  task automatic do_reset();
    rst = 1'b1; wr_en = 1'b0; fs_in = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_fall();
    logic p;
    p = sclk_out;
    @(negedge clk);
    while (!(p && !sclk_out)) begin
      p = sclk_out;
      @(negedge clk);
    end
  endtask

  task automatic write_words();
    for (int k = 0; k < g_n; k++) begin
      if (k == 7) chk(wr_full == 1'b0, "R3 not full at 7", wr_full, 0);
      if (k == 8) chk(wr_full == 1'b1, "R3 full at 8", wr_full, 1);
      wr_en = 1'b1; wr_data = wv[k];
      @(negedge clk);
    end
    wr_en = 1'b0;
  endtask

  task automatic apply_cfg(input int L, input bit lsb, input bit on, input bit fint,
                           input bit low, input bit wide, input bit late, input int n);
    g_L = L; g_lsb = lsb; g_on = on; g_int = fint; g_low = low; g_wide = wide;
    g_late = late; g_n = n;
    cfg_len_m1 = 5'(L - 1); cfg_lsb_first = lsb; cfg_fs_on = on; cfg_fs_int = fint;
    cfg_fs_low = low; cfg_fs_wide = wide; cfg_fs_late = late;
    for (int k = 0; k < 16; k++) wv[k] = mkword(k, L);
  endtask

  task automatic run_stream(input int L, input bit lsb, input bit on, input bit fint,
                            input bit low, input bit wide, input bit late,
                            input int n, input int slots, input string tag);
    logic esd, efs, edn;
    apply_cfg(L, lsb, on, fint, low, wide, late, n);
    cfg_int_clk = 1'b1; cfg_div = 16'd4;
    do_reset();
    chk(sd_out == 1'b0 && word_done == 1'b0 && uflow_err == 1'b0, "reset outputs",
        {sd_out, word_done, uflow_err}, 0);
    chk(fs_out == low, "R7 reset frame sync level", fs_out, low);
    write_words();
    for (int j = 0; j < slots; j++) begin
      wait_fall();
      exp_slot(j, esd, efs, edn);
      chk(sd_out == esd, {tag, " data R1 R2 R6"}, sd_out, esd);
      chk(fs_out == efs, {tag, " frame sync R7 R8 R9 R10"}, fs_out, efs);
      chk(word_done == edn, {tag, " done R12"}, word_done, edn);
    end
    chk(uflow_err == ((slots - lead_slots()) > n_eff() * L), {tag, " underflow R13"},
        uflow_err, ((slots - lead_slots()) > n_eff() * L));
  endtask

  task automatic measure(input int d);
    int n;
    logic p;
    bit seen;
    cfg_int_clk = 1'b1; cfg_div = 16'(d);
    do_reset();
    wait_fall();
    n = 0; p = sclk_out; seen = 1'b0;
    while (!seen) begin
      @(negedge clk);
      n++;
      if (p && !sclk_out) seen = 1'b1;
      p = sclk_out;
    end
    chk(n == 2 * (d + 1), "R4 divider period", n, 2 * (d + 1));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic esd, efs, edn;

    // R1 R2 R6 R13: every length, both bit orders, late narrow sync, underflow at the end
    for (int L = 3; L <= 32; L++)
      for (int b = 0; b < 2; b++)
        run_stream(L, b[0], 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 2, 2 * L + 1, "sweep");

    // R7 R8 R9 R10: every frame sync mode in both polarities
    for (int low = 0; low < 2; low++) begin
      run_stream(5, 1'b0, 1'b0, 1'b1, low[0], 1'b0, 1'b1, 3, 17, "R7 none");
      run_stream(5, 1'b0, 1'b1, 1'b1, low[0], 1'b0, 1'b1, 3, 17, "R8 late narrow");
      run_stream(5, 1'b1, 1'b1, 1'b1, low[0], 1'b1, 1'b1, 3, 17, "R8 late wide");
      run_stream(5, 1'b0, 1'b1, 1'b1, low[0], 1'b0, 1'b0, 3, 17, "R9 early narrow");
      run_stream(5, 1'b1, 1'b1, 1'b1, low[0], 1'b1, 1'b0, 3, 17, "R9 early wide");
    end

    // R13: exactly the written words, no underflow yet
    run_stream(6, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 3, 18, "R13 no underflow");

    // R3: ninth write meets a full queue and is dropped; R13 repeat of word 8
    run_stream(4, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 9, 40, "R3 full drop");

    // R4: divider periods
    measure(0);
    measure(1);
    measure(6);
    measure(300);

    // R5: external serial clock, no frame sync, one word then repeat
    apply_cfg(4, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1);
    cfg_int_clk = 1'b0;
    do_reset();
    write_words();
    for (int j = 0; j < 6; j++) begin
      sclk_in = 1'b1;
      repeat (6) @(negedge clk);
      sclk_in = 1'b0;
      repeat (5) @(negedge clk);
      exp_slot(j, esd, efs, edn);
      chk(sd_out == esd, "R5 external clock data", sd_out, esd);
      chk(sclk_out == 1'b0, "R5 sclk_out held low", sclk_out, 0);
    end

    // R11: external frame sync, late then early
    apply_cfg(8, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2);
    cfg_int_clk = 1'b1; cfg_div = 16'd4;
    do_reset();
    write_words();
    for (int j = 0; j < 2; j++) begin
      wait_fall();
      chk(sd_out == 1'b0, "R11 waits for frame sync", sd_out, 0);
    end
    fs_in = 1'b1;
    wait_fall();
    fs_in = 1'b0;
    chk(sd_out == wv[0][7], "R11 late first bit", sd_out, wv[0][7]);
    for (int b = 1; b < 8; b++) begin
      wait_fall();
      chk(sd_out == wv[0][7-b], "R11 late word bits", sd_out, wv[0][7-b]);
    end
    chk(fs_out == 1'b0, "R7 R11 no frame sync output", fs_out, 0);
    wait_fall();
    chk(sd_out == 1'b0, "R11 idle after word", sd_out, 0);
    chk(word_done == 1'b1, "R12 done external", word_done, 1);
    cfg_fs_late = 1'b0;
    fs_in = 1'b1;
    wait_fall();
    fs_in = 1'b0;
    chk(sd_out == 1'b0, "R11 early lead slot", sd_out, 0);
    for (int b = 0; b < 8; b++) begin
      wait_fall();
      chk(sd_out == wv[1][7-b], "R11 early word bits", sd_out, wv[1][7-b]);
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule